// File: doc/BRIEF.md
# Configuration Item DMA Descriptor Engine

This block serves a table of small configuration items to memory on behalf of software. A start pulse hands it the address of a 16-byte descriptor held in memory. The engine reads the descriptor one byte at a time through a byte-wide memory master port. The descriptor carries a control word, a byte count and a destination address, all stored most-significant byte first. Depending on the control word, the engine can first switch to another item. It then either copies bytes of the current item to the destination or advances the item's read position without moving data. Finally it writes a completion word back over the descriptor's control field.

The current item index and byte offset live in one cursor. The engine and a simpler selector port both use this cursor. The selector port loads a new index whenever the engine is idle. Item contents and lengths come from a small built-in table. Reading beyond an item's end, or reading from an item that does not exist, produces zero bytes.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, busy, done and mem_req are low, and the cursor reads item 0 at offset 0.
- R2: A start pulse makes the engine fetch the 16 descriptor bytes at start_addr+0 through start_addr+15 in ascending order. The fields are: control from bytes 0..3, length from bytes 4..7, destination from bytes 8..15. Each field is big-endian.
- R3: When control bit 3 is set, the cursor moves to the item index in control bits 31:16 with offset 0 before any data moves. A sel_wr pulse while idle does the same with sel_idx. A sel_wr pulse while busy is ignored.
- R4: When control bit 1 (read) is set, the engine writes length bytes to ascending destination addresses. The first min(length, bytes left in item) of them are item bytes from the current offset, and the rest are zero. The offset advances by the number of item bytes copied.
- R5: When control bit 2 (skip) is set and bit 1 is clear, the offset advances by min(length, bytes left in item) and only the status word is written. Bit 1 takes priority when both are set.
- R6: When neither bit 1 nor bit 2 is set, no data is written and the offset is unchanged. A select in bit 3 still takes effect.
- R7: An index of NUM_ITEMS or above, an item of length 0, or an offset already at the item's end makes a read produce only zero bytes, with the offset unchanged.
- R8: An error response on a descriptor fetch ends the operation. No select or transfer follows, and the status word 0x00000001 is written.
- R9: An error response on a data write stops the transfer and sets status to 0x00000001. The offset still advances by the whole chunk that was in progress: min(remaining length, bytes left) counted at the failing byte.
- R10: Completion writes the 32-bit status big-endian to start_addr+0..3. The value is 0 on success, or bit 0 set on error. busy is high from the cycle after start until the last status byte is acknowledged. done then pulses for exactly one cycle.
- R11: mem_req, mem_we, mem_addr and mem_wdata hold steady from the raise of mem_req until the cycle in which mem_ack is seen.
- R12: Item i (i < NUM_ITEMS) has length (3*i) mod 13 bytes, and its byte k equals {i[3:0], k[3:0]} XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a descriptor |
| start_addr | input | 64 | Descriptor address, sampled with start |
| sel_wr | input | 1 | Selector port write strobe |
| sel_idx | input | 16 | Item index for the selector port |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_item | output | 16 | Current item index |
| cur_off | output | 32 | Current byte offset in the item |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Request accepted, one cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |

## Verification
A wrong cursor value is visible on cur_item and cur_off one cycle after the select or skip that should have set it. Within the same descriptor, it also appears as shifted or zero data bytes at the destination. A miscounted fetch or status index corrupts the decoded fields or the completion word. The bench sees this in memory right after the done pulse. A fault in error handling shows up in three places: the status byte, the number of writes issued, and the final offset.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam int CTL_W     = 32;
  localparam int LEN_W     = 32;
  localparam int DST_W     = 64;
  localparam int DESC_W    = CTL_W + LEN_W + DST_W;
  localparam int DESC_B    = DESC_W / 8;
  localparam int STAT_B    = CTL_W / 8;
  localparam int IDX_W     = 16;

  localparam int BIT_ERR   = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_SKIP  = 2;
  localparam int BIT_SEL   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_SKIP,
    ST_XFER,
    ST_STAT,
    ST_DONE
  } eng_state_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic [LEN_W-1:0] len;
    logic [DST_W-1:0] dst;
  } desc_t;
endpackage

// File: rtl/cfgdma_item_rom.sv
module cfgdma_item_rom #(
  parameter int NUM_ITEMS = 8,
  parameter int LEN_STEP  = 3,
  parameter int LEN_MOD   = 13,
  parameter int OFF_W     = 32
) (
  input  logic [cfgdma_pkg::IDX_W-1:0] item,
  input  logic [OFF_W-1:0]             off,
  output logic                         valid,
  output logic [OFF_W-1:0]             len,
  output logic [7:0]                   data
);
  localparam int SEL_W = (NUM_ITEMS > 1) ? $clog2(NUM_ITEMS) : 1;

  logic [OFF_W-1:0] len_tab [NUM_ITEMS];

  for (genvar gi = 0; gi < NUM_ITEMS; gi++) begin : g_len
    assign len_tab[gi] = OFF_W'((gi * LEN_STEP) % LEN_MOD);
  end

  always_comb begin
    valid = (32'(item) < NUM_ITEMS);
    len   = '0;
    if (valid) begin
      len = len_tab[item[SEL_W-1:0]];
    end
    data = {item[3:0], off[3:0]} ^ 8'hA5;
  end
endmodule

// File: rtl/cfgdma_cursor.sv
module cfgdma_cursor #(
  parameter int OFF_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [cfgdma_pkg::IDX_W-1:0] ld_idx,
  input  logic                         adv_en,
  input  logic [OFF_W-1:0]             adv_amt,
  input  logic                         item_valid,
  input  logic [OFF_W-1:0]             item_len,
  output logic [cfgdma_pkg::IDX_W-1:0] cur_item,
  output logic [OFF_W-1:0]             cur_off,
  output logic                         in_range,
  output logic [OFF_W-1:0]             left
);
  logic [cfgdma_pkg::IDX_W-1:0] item_d;
  logic [OFF_W-1:0]             off_d;
  logic                         upd;

  always_comb begin
    in_range = item_valid && (cur_off < item_len);
    left     = in_range ? (item_len - cur_off) : '0;
    upd      = ld_en || adv_en;
    item_d   = cur_item;
    off_d    = cur_off;
    if (ld_en) begin
      item_d = ld_idx;
      off_d  = '0;
    end else if (adv_en) begin
      off_d  = cur_off + adv_amt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_item <= '0;
      cur_off  <= '0;
    end else if (upd) begin
      cur_item <= item_d;
      cur_off  <= off_d;
    end
  end

  AST_SEL_RESETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cur_off == '0) && (cur_item == $past(ld_idx))); // R3
  AST_OFF_WITHIN_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid && !ld_en && !$past(ld_en)) |-> (cur_off <= item_len)); // R4
endmodule

// File: rtl/cfgdma_fsm.sv
module cfgdma_fsm #(
  parameter int OFF_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [cfgdma_pkg::DST_W-1:0] start_addr,
  input  logic                         mem_ack,
  input  logic                         mem_err,
  input  logic [7:0]                   mem_rdata,
  input  logic                         cur_in_range,
  input  logic [OFF_W-1:0]             cur_left,
  input  logic [7:0]                   rom_data,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [cfgdma_pkg::DST_W-1:0] mem_addr,
  output logic [7:0]                   mem_wdata,
  output logic                         busy,
  output logic                         done,
  output logic                         sel_ld,
  output logic [cfgdma_pkg::IDX_W-1:0] sel_idx,
  output logic                         adv_en,
  output logic [OFF_W-1:0]             adv_amt
);
  import cfgdma_pkg::*;

  localparam int CNT_W = $clog2(DESC_B);

  eng_state_e          state_q, state_d;
  logic [DST_W-1:0]    base_q, base_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  desc_t               desc_q, desc_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic [DST_W-1:0]    dst_q, dst_d;
  logic                err_q, err_d;
  logic [OFF_W-1:0]    chunk;
  logic                want_rd, want_skip;

  always_comb begin
    chunk     = (OFF_W'(rem_q) < cur_left) ? OFF_W'(rem_q) : cur_left;
    want_rd   = desc_q.ctl[BIT_RD];
    want_skip = desc_q.ctl[BIT_SKIP] && !desc_q.ctl[BIT_RD];

    state_d   = state_q;
    base_d    = base_q;
    cnt_d     = cnt_q;
    desc_d    = desc_q;
    rem_d     = rem_q;
    dst_d     = dst_q;
    err_d     = err_q;

    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    sel_ld    = 1'b0;
    sel_idx   = desc_q.ctl[CTL_W-1 -: IDX_W];
    adv_en    = 1'b0;
    adv_amt   = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          base_d  = start_addr;
          cnt_d   = '0;
          err_d   = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + DST_W'(cnt_q);
        if (mem_ack) begin
          if (mem_err) begin
            err_d   = 1'b1;
            cnt_d   = '0;
            state_d = ST_STAT;
          end else begin
            desc_d = desc_t'({desc_q[DESC_W-9:0], mem_rdata});
            cnt_d  = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DESC_B - 1)) begin
              state_d = ST_DECODE;
            end
          end
        end
      end
      ST_DECODE: begin
        sel_ld = desc_q.ctl[BIT_SEL];
        dst_d  = desc_q.dst;
        rem_d  = desc_q.len;
        if ((!want_rd && !want_skip) || (desc_q.len == '0)) begin
          state_d = ST_STAT;
        end else if (want_rd) begin
          state_d = ST_XFER;
        end else begin
          state_d = ST_SKIP;
        end
      end
      ST_SKIP: begin
        adv_en  = 1'b1;
        adv_amt = chunk;
        state_d = ST_STAT;
      end
      ST_XFER: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q;
        mem_wdata = cur_in_range ? rom_data : 8'h00;
        if (mem_ack) begin
          if (mem_err) begin
            err_d   = 1'b1;
            adv_en  = cur_in_range;
            adv_amt = chunk;
            state_d = ST_STAT;
          end else begin
            adv_en  = cur_in_range;
            adv_amt = OFF_W'(1);
            rem_d   = rem_q - 1'b1;
            dst_d   = dst_q + 1'b1;
            if (rem_q == LEN_W'(1)) begin
              state_d = ST_STAT;
            end
          end
        end
      end
      ST_STAT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = base_q + DST_W'(cnt_q);
        if (cnt_q == CNT_W'(STAT_B - 1)) begin
          mem_wdata = {7'b0, err_q};
        end
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(STAT_B - 1)) begin
            state_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
    done = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      desc_q  <= '0;
      rem_q   <= '0;
      dst_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      desc_q  <= desc_d;
      rem_q   <= rem_d;
      dst_q   <= dst_d;
      err_q   <= err_d;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata))); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R10
  AST_FETCH_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && mem_ack && mem_err) |=> (!sel_ld && !adv_en && mem_we)); // R8
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int NUM_ITEMS = 8,
  parameter int LEN_STEP  = 3,
  parameter int LEN_MOD   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] start_addr,
  input  logic        sel_wr,
  input  logic [15:0] sel_idx,
  output logic        busy,
  output logic        done,
  output logic [15:0] cur_item,
  output logic [31:0] cur_off,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_err
);
  localparam int OFF_W = cfgdma_pkg::LEN_W;

  logic             eng_sel_ld;
  logic [15:0]      eng_sel_idx;
  logic             adv_en;
  logic [OFF_W-1:0] adv_amt;
  logic             ld_en;
  logic [15:0]      ld_idx;
  logic             item_valid;
  logic [OFF_W-1:0] item_len;
  logic [7:0]       rom_data;
  logic             in_range;
  logic [OFF_W-1:0] left;

  always_comb begin
    ld_en  = eng_sel_ld || (sel_wr && !busy);
    ld_idx = eng_sel_ld ? eng_sel_idx : sel_idx;
  end

  cfgdma_item_rom #(
    .NUM_ITEMS(NUM_ITEMS), .LEN_STEP(LEN_STEP), .LEN_MOD(LEN_MOD), .OFF_W(OFF_W)
  ) u_rom (
    .item(cur_item), .off(cur_off), .valid(item_valid), .len(item_len), .data(rom_data)
  );

  cfgdma_cursor #(.OFF_W(OFF_W)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx),
    .adv_en(adv_en), .adv_amt(adv_amt),
    .item_valid(item_valid), .item_len(item_len),
    .cur_item(cur_item), .cur_off(cur_off),
    .in_range(in_range), .left(left)
  );

  cfgdma_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_addr(start_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cur_in_range(in_range), .cur_left(left), .rom_data(rom_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done),
    .sel_ld(eng_sel_ld), .sel_idx(eng_sel_idx),
    .adv_en(adv_en), .adv_amt(adv_amt)
  );

  AST_BUSY_BLOCKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_wr && !eng_sel_ld) |=> (cur_item == $past(cur_item))); // R3
endmodule

// File: tb/tb_cfg_dma_engine.sv
module tb_cfg_dma_engine;
  logic        clk, rst_n;
  logic        start, sel_wr;
  logic [63:0] start_addr;
  logic [15:0] sel_idx;
  logic        busy, done;
  logic [15:0] cur_item;
  logic [31:0] cur_off;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  cfg_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .sel_wr(sel_wr), .sel_idx(sel_idx), .busy(busy), .done(done),
    .cur_item(cur_item), .cur_off(cur_off), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mem [0:1023];
  int wr_cnt, rd_n, wait_cnt;
  logic [63:0] rd_log [0:31];
  logic err_en;
  logic [63:0] err_addr;
  logic [15:0] m_item;
  logic [31:0] m_off;
  logic [7:0] exp_b [0:63];
  logic       exp_w [0:63];

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      report_end();
    end
  end

  // memory responder: acknowledges after 0-2 idle negedges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 8'h00; wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        mem_err = err_en && (mem_addr == err_addr);
        if (mem_we) begin
          wr_cnt++;
          if (!mem_err) mem[mem_addr[9:0]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[9:0]];
          if (rd_n < 32) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
        wait_cnt = $urandom % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R12 item model
  function automatic logic [31:0] item_len(input logic [15:0] i);
    return (i < 8) ? 32'((32'(i) * 3) % 13) : 32'd0;
  endfunction
  function automatic logic [7:0] item_byte(input logic [15:0] i, input logic [31:0] k);
    return {i[3:0], k[3:0]} ^ 8'hA5;
  endfunction

  task automatic run_desc(input logic [63:0] base, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] dst,
                          input logic e_en, input logic [63:0] e_addr,
                          input logic sel_busy, input string tag);
    logic fetch_err, werr;
    logic [7:0] status;
    int nwr, bad;
    logic [31:0] L;
    for (int k = 0; k < 4; k++) begin
      mem[base[9:0] + k]      = ctl[31-8*k -: 8];
      mem[base[9:0] + 4 + k]  = len[31-8*k -: 8];
    end
    for (int k = 0; k < 8; k++) mem[base[9:0] + 8 + k] = dst[63-8*k -: 8];
    for (int k = 0; k < 64; k++) begin exp_w[k] = 1'b0; exp_b[k] = 8'hEE; end
    for (int k = 0; k < 42; k++) mem[dst[9:0] + k] = 8'hEE;
    // model
    fetch_err = e_en && (e_addr >= base) && (e_addr < base + 16);
    status = 8'h00; nwr = 0;
    if (fetch_err) status = 8'h01;
    else begin
      if (ctl[3]) begin m_item = ctl[31:16]; m_off = 0; end
      L = item_len(m_item);
      if (ctl[1]) begin
        werr = 1'b0;
        for (int k = 0; k < int'(len) && !werr; k++) begin
          logic inr;
          inr = (m_item < 8) && (m_off < L);
          nwr++;
          if (e_en && (dst + 64'(k) == e_addr)) begin
            werr = 1'b1; status = 8'h01;
            if (inr) m_off += ((len - 32'(k)) < (L - m_off)) ? (len - 32'(k)) : (L - m_off);
          end else begin
            exp_w[k] = 1'b1;
            exp_b[k] = inr ? item_byte(m_item, m_off) : 8'h00;
            if (inr) m_off++;
          end
        end
      end else if (ctl[2]) begin
        if ((m_item < 8) && (m_off < L))
          m_off += (len < (L - m_off)) ? len : (L - m_off);
      end
    end
    err_en = e_en; err_addr = e_addr; wr_cnt = 0; rd_n = 0;
    @(negedge clk); start = 1'b1; start_addr = base;
    @(negedge clk); start = 1'b0;
    chk({tag, " R10 busy after start"}, busy, 1);
    if (sel_busy) begin
      repeat (3) @(negedge clk);
      sel_wr = 1'b1; sel_idx = 16'd5;
      @(negedge clk); sel_wr = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({tag, " R10 busy low at done"}, busy, 0);
    @(negedge clk);
    chk({tag, " R10 done single pulse"}, done, 0);
    err_en = 1'b0;
    bad = 0;
    for (int k = 0; k < 42; k++) if (mem[dst[9:0] + k] !== exp_b[k]) bad++;
    chk({tag, " R4/R7 destination bytes mismatches"}, bad, 0);
    chk({tag, " R10 status word"},
        {mem[base[9:0]], mem[base[9:0]+1], mem[base[9:0]+2], mem[base[9:0]+3]}, {24'h0, status});
    chk({tag, " R5/R6 write count"}, wr_cnt, nwr + 4);
    chk({tag, " R3 item"}, cur_item, m_item);
    chk({tag, " R4/R5 offset"}, cur_off, m_off);
    if (!fetch_err) begin
      bad = (rd_n == 16) ? 0 : 1;
      for (int k = 0; k < 16 && k < rd_n; k++) if (rd_log[k] !== base + 64'(k)) bad++;
      chk({tag, " R2 fetch order"}, bad, 0);
    end
  endtask

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; start = 1'b0; sel_wr = 1'b0; start_addr = '0; sel_idx = '0;
    err_en = 1'b0; err_addr = '0; wr_cnt = 0; rd_n = 0;
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    m_item = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 item/offset", {cur_item, cur_off}, 48'h0);
    // R3 selector port while idle
    sel_wr = 1'b1; sel_idx = 16'd4;
    @(negedge clk); sel_wr = 1'b0;
    m_item = 4; m_off = 0;
    chk("R3 selector port item", cur_item, 4);
    chk("R3 selector port offset", cur_off, 0);
    run_desc(64'd0,  32'h0000_0002, 5,  64'd256, 0, 0, 0, "rd5");
    run_desc(64'd16, 32'h0000_0002, 10, 64'd320, 0, 0, 0, "rd_tail_R4");
    run_desc(64'd32, 32'h0000_0002, 4,  64'd384, 0, 0, 0, "rd_end_R7");
    run_desc(64'd48, 32'h0009_000A, 3,  64'd448, 0, 0, 0, "invalid_R7");
    run_desc(64'd64, 32'h0000_000A, 3,  64'd512, 0, 0, 0, "empty_R7");
    run_desc(64'd80, 32'h0007_000C, 3,  64'd576, 0, 0, 0, "skip_R5");
    run_desc(64'd96, 32'h0000_0004, 20, 64'd640, 0, 0, 0, "skip_end_R5");
    run_desc(64'd0,  32'h0006_0008, 5,  64'd700, 0, 0, 0, "none_R6");
    run_desc(64'd16, 32'h0003_000A, 5,  64'd760, 1, 64'd22, 0, "fetch_err_R8");
    run_desc(64'd32, 32'h0004_000A, 10, 64'd800, 1, 64'd802, 0, "wr_err_R9");
    run_desc(64'd48, 32'h0002_000E, 3,  64'd850, 0, 0, 0, "rd_over_skip_R5");
    run_desc(64'd64, 32'h0007_000A, 0,  64'd900, 0, 0, 0, "zero_len_R6");
    run_desc(64'd80, 32'h0007_000A, 4,  64'd300, 0, 0, 1, "sel_busy_R3");
    for (int n = 0; n < 40; n++) begin
      logic [63:0] b, d, ea;
      logic [31:0] c, l;
      logic ee;
      b = 64'(16 * ($urandom % 8));
      d = 64'(256 + $urandom % 600);
      l = $urandom % 21;
      c = {16'($urandom % 10), 12'h0, 1'b0, 3'($urandom % 8)};
      ee = ($urandom % 5) == 0;
      ea = (($urandom % 2) == 0) ? b + 64'(4 + $urandom % 12) : d + 64'($urandom % 21);
      run_desc(b, c, l, d, ee, ea, ($urandom % 4) == 0, "random R4 R5 R9");
    end
    report_end();
  end
endmodule